// File: doc/BRIEF.md
# Bit Test and Modify Unit

This execution unit carries out the four bit-test operations of a general-purpose integer pipeline: a plain test, and a test followed by complementing, clearing or setting the selected bit. Each request names an operand of 16, 32 or 64 bits, a bit index, an operation code and an operand size. One cycle later the unit returns the new operand value, the carry flag and a write-back enable. The carry flag always holds the chosen bit as it was before any change. The single-bit mask is made by rotating a seed pattern by the index. The seed is a lone one for complement and set, and all ones except bit 0 for clear.

The same request also yields an effective word address for the memory forms. The bit index is read as a signed bit offset, shifted right arithmetically by the base-2 log of the operand size in bytes, and added to a base address. A negative offset therefore reaches a word below the base. For a memory form, the surrounding pipeline loads the word at that address and passes it in as the operand. It then stores the returned value when the write-back enable is high. The unit itself performs no memory access.

Top module: `bit_test_unit`

## Requirements
- R1: While reset is held and after its release, before any request, outValid, outWrEn, outCarry, outResult and outAddr are all zero.
- R2: outValid equals inValid of the previous clock cycle, so back-to-back requests each produce one result one cycle later.
- R3: outCarry holds the value of operand bit (index mod width) as it was before modification, for every operation.
- R4: Operation code 00 (test) returns the operand unchanged, apart from zero-extension, and raises no write-back.
- R5: Operation code 01 (complement) inverts only the selected bit.
- R6: Operation code 10 (clear) forces only the selected bit to 0.
- R7: Operation code 11 (set) forces only the selected bit to 1.
- R8: Index bits at and above log2(width) have no effect on the selected bit or on the carry.
- R9: Size code 01 selects 16 bits, 10 selects 32 bits and 11 selects 64 bits; code 00 behaves as 16 bits. Operand bits above the selected width are ignored, and outResult is zero above it.
- R10: outAddr equals inBase plus the index read as a signed value, arithmetically shifted right by 1, 2 or 3 for widths 16, 32 or 64.
- R11: outWrEn is high exactly when outValid is high and the operation was complement, clear or set.
- R12: In a cycle with inValid low, outResult, outCarry and outAddr keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request present this cycle |
| inOp | input | 2 | Operation: 00 test, 01 complement, 10 clear, 11 set |
| inSize | input | 2 | Operand size: 01 16-bit, 10 32-bit, 11 64-bit, 00 as 16-bit |
| inOperand | input | DATA_W | Register value or loaded memory word |
| inIndex | input | DATA_W | Bit index, also the signed bit offset for addressing |
| inBase | input | ADDR_W | Base address for memory forms |
| outValid | output | 1 | Result present this cycle |
| outResult | output | DATA_W | Modified operand, zero-extended |
| outCarry | output | 1 | Selected bit before modification |
| outWrEn | output | 1 | Write back or store the result |
| outAddr | output | ADDR_W | Effective word address |

## Verification
The bench targets the boundary bit positions 0 and width-1 at each size. A rotate that is off by one, or a seed that is not inverted for clear, would touch the wrong bit or several bits at those positions. It drives indices with junk in the upper bits and operands with junk above the chosen width, which exposes a design that indexes past the width or fails to zero-extend. Negative offsets check that the address shift keeps the sign: a logical shift would produce an address far above the base. Idle gaps between requests show whether the outputs drift, or whether write-back leaks into a cycle with no result.

// File: rtl/bit_test_pkg.sv
package bit_test_pkg;

  typedef enum logic [1:0] {
    OP_TEST  = 2'b00,
    OP_FLIP  = 2'b01,
    OP_CLEAR = 2'b10,
    OP_SET   = 2'b11
  } bitOpE;

  typedef enum logic [1:0] {
    SZ_RSV = 2'b00,
    SZ_16  = 2'b01,
    SZ_32  = 2'b10,
    SZ_64  = 2'b11
  } opSizeE;

  // number of supported operand widths and the narrowest one
  localparam int NUM_WIDTHS = 3;
  localparam int MIN_WIDTH  = 16;
  localparam int MAX_WIDTH  = MIN_WIDTH << (NUM_WIDTHS - 1);

  // strobes from control to datapath
  typedef struct packed {
    logic                  load;
    logic                  useXor;
    logic                  useAnd;
    logic                  useOr;
    logic [NUM_WIDTHS-1:0] widthSel;
    logic [1:0]            addrShift;
  } ctrlStrobeT;

endpackage

// File: rtl/bit_test_ctrl.sv
module bit_test_ctrl
  import bit_test_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inOp,
  input  logic [1:0] inSize,
  output ctrlStrobeT strobe,
  output logic       outValid,
  output logic       outWrEn
);

  bitOpE  opCode;
  opSizeE sizeCode;
  logic   modifies;

  assign opCode   = bitOpE'(inOp);
  assign sizeCode = opSizeE'(inSize);
  assign modifies = (opCode != OP_TEST);

  always_comb begin
    strobe          = '0;
    strobe.load     = inValid;
    strobe.useXor   = (opCode == OP_FLIP);
    strobe.useAnd   = (opCode == OP_CLEAR);
    strobe.useOr    = (opCode == OP_SET);
    unique case (sizeCode)
      SZ_32: begin
        strobe.widthSel  = 3'b010;
        strobe.addrShift = 2'd2;
      end
      SZ_64: begin
        strobe.widthSel  = 3'b100;
        strobe.addrShift = 2'd3;
      end
      default: begin
        strobe.widthSel  = 3'b001;
        strobe.addrShift = 2'd1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWrEn  <= 1'b0;
    end else begin
      outValid <= inValid;
      outWrEn  <= inValid && modifies;
    end
  end

endmodule

// File: rtl/bit_test_datapath.sv
module bit_test_datapath
  import bit_test_pkg::*;
#(
  parameter int DATA_W = MAX_WIDTH,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [DATA_W-1:0] inOperand,
  input  logic [DATA_W-1:0] inIndex,
  input  logic [ADDR_W-1:0] inBase,
  output logic [DATA_W-1:0] outResult,
  output logic              outCarry,
  output logic [ADDR_W-1:0] outAddr
);

  logic [DATA_W-1:0]     resultG [NUM_WIDTHS];
  logic [NUM_WIDTHS-1:0] carryG;
  logic [DATA_W-1:0]     nextResult;
  logic                  nextCarry;
  logic [ADDR_W-1:0]     nextAddr;

  // one mask-and-apply lane per operand width
  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : gLane
    localparam int W  = MIN_WIDTH << g;
    localparam int KW = $clog2(W);

    logic [W-1:0]   word;
    logic [W-1:0]   seed;
    logic [2*W-1:0] doubled;
    logic [W-1:0]   mask;
    logic [W-1:0]   modified;
    logic [KW-1:0]  pos;

    assign word    = inOperand[W-1:0];
    assign pos     = inIndex[KW-1:0];
    assign seed    = strobe.useAnd ? ~W'(1) : W'(1);
    assign doubled = {seed, seed} << pos;
    assign mask    = doubled[2*W-1:W];

    always_comb begin
      if (strobe.useXor)      modified = word ^ mask;
      else if (strobe.useAnd) modified = word & mask;
      else if (strobe.useOr)  modified = word | mask;
      else                    modified = word;
    end

    assign carryG[g]  = word[pos];
    assign resultG[g] = DATA_W'(modified);
  end

  always_comb begin
    nextResult = '0;
    nextCarry  = 1'b0;
    for (int g = 0; g < NUM_WIDTHS; g++) begin
      if (strobe.widthSel[g]) begin
        nextResult = resultG[g];
        nextCarry  = carryG[g];
      end
    end
  end

  // signed bit offset to word address
  logic signed [DATA_W-1:0] offsetS;
  logic signed [DATA_W-1:0] wordOffset;

  assign offsetS    = $signed(inIndex);
  assign wordOffset = offsetS >>> strobe.addrShift;
  assign nextAddr   = inBase + ADDR_W'(wordOffset);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outResult <= '0;
      outCarry  <= 1'b0;
      outAddr   <= '0;
    end else if (strobe.load) begin
      outResult <= nextResult;
      outCarry  <= nextCarry;
      outAddr   <= nextAddr;
    end
  end

endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
  import bit_test_pkg::*;
#(
  parameter int DATA_W = MAX_WIDTH,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inOp,
  input  logic [1:0]        inSize,
  input  logic [DATA_W-1:0] inOperand,
  input  logic [DATA_W-1:0] inIndex,
  input  logic [ADDR_W-1:0] inBase,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult,
  output logic              outCarry,
  output logic              outWrEn,
  output logic [ADDR_W-1:0] outAddr
);

  ctrlStrobeT strobe;

  bit_test_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inOp    (inOp),
    .inSize  (inSize),
    .strobe  (strobe),
    .outValid(outValid),
    .outWrEn (outWrEn)
  );

  bit_test_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inOperand(inOperand),
    .inIndex  (inIndex),
    .inBase   (inBase),
    .outResult(outResult),
    .outCarry (outCarry),
    .outAddr  (outAddr)
  );

endmodule

// File: rtl/bit_test_checker.sv
module bit_test_checker #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        inOp,
  input logic [1:0]        inSize,
  input logic [DATA_W-1:0] inOperand,
  input logic [DATA_W-1:0] inIndex,
  input logic [ADDR_W-1:0] inBase,
  input logic              outValid,
  input logic [DATA_W-1:0] outResult,
  input logic              outCarry,
  input logic              outWrEn,
  input logic [ADDR_W-1:0] outAddr
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2

  AST_NO_WREN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !outWrEn); // R11

  AST_MODIFY_WREN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp != 2'b00) |=> outWrEn); // R11

  AST_TEST_NO_WREN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'b00) |=> !outWrEn); // R4

  AST_SET_BIT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'b11 && inSize == 2'b11) |=> outResult[$past(inIndex[5:0])]); // R7

  AST_CLEAR_BIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'b10 && inSize == 2'b11) |=> !outResult[$past(inIndex[5:0])]); // R6

  AST_ZERO_EXTEND_16: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSize == 2'b01) |=> (outResult[DATA_W-1:16] == '0)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outResult) && $stable(outCarry) && $stable(outAddr))); // R12

endmodule

bind bit_test_unit bit_test_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bit_test_unit_tb.sv
module bit_test_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [1:0]    inOp = '0;
  logic [1:0]    inSize = '0;
  logic [DW-1:0] inOperand = '0;
  logic [DW-1:0] inIndex = '0;
  logic [AW-1:0] inBase = '0;
  logic          outValid;
  logic [DW-1:0] outResult;
  logic          outCarry;
  logic          outWrEn;
  logic [AW-1:0] outAddr;

  int vectors = 0;
  int fails = 0;

  // expected state of the registered outputs
  logic          expValid = 1'b0;
  logic [DW-1:0] expResult = '0;
  logic          expCarry = 1'b0;
  logic          expWrEn = 1'b0;
  logic [AW-1:0] expAddr = '0;
  string         expTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_test_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inSize(inSize),
    .inOperand(inOperand), .inIndex(inIndex), .inBase(inBase),
    .outValid(outValid), .outResult(outResult), .outCarry(outCarry),
    .outWrEn(outWrEn), .outAddr(outAddr)
  );

  task automatic compare();
    vectors++;
    if (outValid !== expValid) begin
      fails++;
      $display("FAIL %s outValid got %0b exp %0b", expTag, outValid, expValid);
    end
    if (outWrEn !== expWrEn) begin
      fails++;
      $display("FAIL %s outWrEn got %0b exp %0b", expTag, outWrEn, expWrEn);
    end
    if (outResult !== expResult) begin
      fails++;
      $display("FAIL %s outResult got %h exp %h", expTag, outResult, expResult);
    end
    if (outCarry !== expCarry) begin
      fails++;
      $display("FAIL %s outCarry got %0b exp %0b", expTag, outCarry, expCarry);
    end
    if (outAddr !== expAddr) begin
      fails++;
      $display("FAIL %s outAddr got %h exp %h", expTag, outAddr, expAddr);
    end
  endtask

  // check previous result, then drive the next request and model it
  task automatic step(input logic v, input logic [1:0] op, input logic [1:0] sz,
                      input logic [DW-1:0] opnd, input logic [DW-1:0] idx,
                      input logic [AW-1:0] base, input string tag);
    int width, k, sh;
    logic [DW-1:0] orig, bitm;
    @(negedge clk);
    compare();
    inValid = v; inOp = op; inSize = sz;
    inOperand = opnd; inIndex = idx; inBase = base;
    expTag = tag;
    expValid = v;
    expWrEn = v && (op != 2'b00);
    if (v) begin
      width = (sz == 2'b10) ? 32 : (sz == 2'b11) ? 64 : 16;
      sh    = (sz == 2'b10) ? 2 : (sz == 2'b11) ? 3 : 1;
      k     = int'(idx % width);
      orig  = (width == 64) ? opnd : (opnd & ((64'd1 << width) - 64'd1));
      bitm  = 64'd1 << k;
      expCarry = orig[k];
      case (op)
        2'b00: expResult = orig;
        2'b01: expResult = orig ^ bitm;
        2'b10: expResult = orig & ~bitm;
        default: expResult = orig | bitm;
      endcase
      expAddr = base + AW'($signed(idx) >>> sh);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(); // R1 while in reset
    @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R1");
    // R4 plain test
    step(1, 2'b00, 2'b11, 64'hA5A5_0F0F_1234_5678, 64'd7, 64'h100, "R4");
    // R3 carry from top bit
    step(1, 2'b00, 2'b11, 64'h8000_0000_0000_0000, 64'd63, 64'h0, "R3");
    step(1, 2'b01, 2'b10, 64'h0000_0000_8000_0001, 64'd31, 64'h0, "R5");
    step(1, 2'b01, 2'b01, 64'h0, 64'd0, 64'h0, "R5");
    step(1, 2'b10, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'h0, "R6");
    step(1, 2'b10, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 64'h0, "R6");
    step(1, 2'b11, 2'b11, 64'h0, 64'd40, 64'h0, "R7");
    step(1, 2'b11, 2'b10, 64'h0, 64'd31, 64'h0, "R7");
    step(1, 2'b00, 2'b01, 64'h0020, 64'hFFFF_FFFF_FFFF_FF05, 64'h0, "R8");
    step(1, 2'b11, 2'b10, 64'h0, 64'h0000_0000_0000_0127, 64'h0, "R8");
    step(1, 2'b01, 2'b01, 64'hFFFF_FFFF_FFFF_0000, 64'd15, 64'h0, "R9");
    step(1, 2'b11, 2'b00, 64'hDEAD_BEEF_0000_0000, 64'd3, 64'h0, "R9");
    step(1, 2'b00, 2'b10, 64'hFFFF_FFFF_0000_0001, 64'd32, 64'h0, "R9");
    step(1, 2'b00, 2'b11, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1000, "R10");
    step(1, 2'b01, 2'b10, 64'h0, 64'hFFFF_FFFF_FFFF_FFF7, 64'h2000, "R10");
    step(1, 2'b10, 2'b01, 64'h0, 64'd35, 64'h3000, "R10");
    step(1, 2'b01, 2'b11, 64'h1, 64'd0, 64'h0, "R11");
    step(0, 2'b11, 2'b11, 64'hFFFF, 64'd9, 64'h55, "R12");
    step(0, 2'b01, 2'b01, 64'h1234, 64'd2, 64'h77, "R12");
    step(1, 2'b00, 2'b11, 64'h2, 64'd1, 64'h0, "R11");
    for (int i = 0; i < 300; i++) begin
      step(($urandom % 4) != 0, 2'($urandom), 2'($urandom),
           {$urandom, $urandom}, {$urandom, $urandom} >> ($urandom % 64),
           {$urandom, $urandom}, "R2");
    end
    step(0, 0, 0, 0, 0, 0, "R12");
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule